// File: doc/BRIEF.md
# Latency-Insensitive Accumulator Shell

This block lets a sequential core be joined to other modules over channels whose latency is not known when the design is written. Every channel carries a data word and a valid flag. A cycle with the flag set is an informative event. A cycle with the flag clear is a stalling event, and its data is ignored. The shell wraps a small accumulator core. The core takes one step only when every input channel has an informative event ready, either arriving in that cycle or held from an earlier one. When any channel has nothing ready, the core's state is frozen and all outputs carry stalling events in the next cycle.

A relay-station stage is a chain of registers on both data and valid, with every valid bit cleared by reset. Each stage adds one cycle of delay, so the receiver sees one extra stalling event before the first real one. The shell places a chain of parameter depth on each of its output channels. The same chain module can be placed in front of its inputs to model long wires.

Each input channel has a small holding queue. Events that arrive early wait there until the slower channels catch up. With these queues, the stream of informative outputs does not depend on how many relay stages sit on each channel.

Top module: `lat_ins_shell`

## Requirements
- R1: While reset is high every top-level output valid is 0. After reset falls, the shell issues its first informative event, with data 0, without waiting for any input. With an output chain of depth D it appears D cycles after the last reset edge (sampled after the first rising edge for D=1).
- R2: The core fires only when every input channel has an informative event pending, held or arriving. A firing puts an informative event on every shell output in the next cycle.
- R3: If any input channel has no informative event pending in a cycle, all shell outputs carry stalling events in the next cycle.
- R4: During a stall the accumulator state and the output data words keep their values.
- R5: Informative output number n, counting from 0, equals the sum modulo 2^WIDTH of the data of the first n informative events of every input channel. Each channel is consumed in arrival order, and the data of stalling events has no effect.
- R6: A relay chain of depth w delays valid and data by exactly w cycles, and its valid bits reset to 0. The receiver therefore sees w stalling events before the first informative one. Depth 0 is a plain wire.
- R7: Each input channel holds up to QDEPTH early informative events. The arrival skew between channels must stay within that, and the queue is never written beyond full.
- R8: In every cycle all output channels carry the same valid flag and the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all channels |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | NUM_IN | Per-input flag: 1 informative, 0 stalling |
| inData | input | NUM_IN*WIDTH | Input data words, channel c at bits c*WIDTH upward |
| outValid | output | NUM_OUT | Per-output flag after the output relay chain |
| outData | output | NUM_OUT*WIDTH | Output data words, channel j at bits j*WIDTH upward |

## Verification
The bench sends each event on all three channels in the same cycle, through relay chains of depth 0, 1 and 3. Event k is therefore due at the output exactly five cycles after it is driven: three relay stages on the slowest channel, one shell register and one output stage. The initial event is due one cycle after reset is released. At every falling edge the bench computes whether an output is due that cycle and compares the valid flags exactly, so an early, late, missing or extra event is reported at its cycle. The depth-3 chain is checked separately against the source values driven three cycles earlier.

// File: rtl/lis_shell_pkg.sv
package lis_shell_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic fire;   // all inputs ready: advance core
    logic stall;  // at least one input void: freeze core
  } shellStrobe_t;
endpackage

// File: rtl/lis_relay_chain.sv
module lis_relay_chain #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign outValid = inValid;
      assign outData  = inData;
    end else begin : g_regs
      logic [DEPTH-1:0]            validPipe;
      logic [DEPTH-1:0][WIDTH-1:0] dataPipe;

      always_ff @(posedge clk) begin
        if (rst) begin
          validPipe <= '0;
          dataPipe  <= '0;
        end else begin
          validPipe[0] <= inValid;
          dataPipe[0]  <= inData;
          for (int s = 1; s < DEPTH; s++) begin
            validPipe[s] <= validPipe[s-1];
            dataPipe[s]  <= dataPipe[s-1];
          end
        end
      end

      assign outValid = validPipe[DEPTH-1];
      assign outData  = dataPipe[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/lis_shell_ctrl.sv
module lis_shell_ctrl
  import lis_shell_pkg::*;
#(
  parameter int NUM_IN = 3
) (
  input  logic [NUM_IN-1:0] chanAvail,
  output shellStrobe_t      strobe
);
  logic allReady;

  // AND-causality: every channel must offer an event
  assign allReady     = &chanAvail;
  assign strobe.fire  = allReady;
  assign strobe.stall = ~allReady;
endmodule

// File: rtl/lis_shell_dpath.sv
module lis_shell_dpath
  import lis_shell_pkg::*;
#(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2,
  parameter int WIDTH   = 16,
  parameter int QDEPTH  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_IN-1:0]         inValid,
  input  logic [NUM_IN*WIDTH-1:0]   inData,
  input  shellStrobe_t              strobe,
  output logic [NUM_IN-1:0]         chanAvail,
  output logic [NUM_IN-1:0]         chanFull,
  output logic [NUM_OUT-1:0]        coreValid,
  output logic [NUM_OUT*WIDTH-1:0]  coreData
);
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W = $clog2(QDEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(QDEPTH - 1);

  logic [NUM_IN-1:0][WIDTH-1:0] headData;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  // Per-channel holding queue with bypass of the arriving event
  generate
    for (genvar c = 0; c < NUM_IN; c++) begin : g_chan
      logic [WIDTH-1:0] slotMem [QDEPTH];
      logic [PTR_W-1:0] rdPtr, wrPtr;
      logic [CNT_W-1:0] fillCnt;
      logic             holding, takeSlot, storeIn;
      logic [WIDTH-1:0] arriving;

      assign arriving     = inData[c*WIDTH +: WIDTH];
      assign holding      = (fillCnt != '0);
      assign chanAvail[c] = holding | inValid[c];
      assign chanFull[c]  = (fillCnt == CNT_W'(QDEPTH));
      assign headData[c]  = holding ? slotMem[rdPtr] : arriving;
      assign takeSlot     = strobe.fire & holding;
      // arriving event is kept unless it is consumed directly this cycle
      assign storeIn      = inValid[c] & ~(strobe.fire & ~holding);

      always_ff @(posedge clk) begin
        if (rst) begin
          rdPtr   <= '0;
          wrPtr   <= '0;
          fillCnt <= '0;
        end else begin
          if (storeIn)  wrPtr <= bumpPtr(wrPtr);
          if (takeSlot) rdPtr <= bumpPtr(rdPtr);
          fillCnt <= fillCnt + CNT_W'(storeIn) - CNT_W'(takeSlot);
        end
      end

      always_ff @(posedge clk) begin
        if (!rst && storeIn) slotMem[wrPtr] <= arriving;
      end
    end
  endgenerate

  // Wrapped core: accumulator over all channel heads
  logic [WIDTH-1:0] stepSum, accReg, accNext;

  always_comb begin
    stepSum = '0;
    for (int c = 0; c < NUM_IN; c++) stepSum = stepSum + headData[c];
  end

  assign accNext = accReg + stepSum;

  logic [NUM_OUT-1:0] validReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg   <= '0;
      validReg <= '1;   // first informative event needs no input
    end else if (strobe.fire) begin
      accReg   <= accNext;
      validReg <= '1;
    end else begin
      validReg <= '0;   // clock enable low: state held, void emitted
    end
  end

  assign coreValid = validReg;

  generate
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
      assign coreData[j*WIDTH +: WIDTH] = accReg;
    end
  endgenerate
endmodule

// File: rtl/lat_ins_shell.sv
module lat_ins_shell
  import lis_shell_pkg::*;
#(
  parameter int NUM_IN    = 3,
  parameter int NUM_OUT   = 2,
  parameter int WIDTH     = 16,
  parameter int QDEPTH    = 4,
  parameter int OUT_DEPTH = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*WIDTH-1:0]  inData,
  output logic [NUM_OUT-1:0]       outValid,
  output logic [NUM_OUT*WIDTH-1:0] outData
);
  shellStrobe_t             strobe;
  logic [NUM_IN-1:0]        chanAvail;
  logic [NUM_IN-1:0]        chanFull;
  logic [NUM_OUT-1:0]       coreValid;
  logic [NUM_OUT*WIDTH-1:0] coreData;
  logic                     fireNow;

  assign fireNow = strobe.fire;

  lis_shell_ctrl #(.NUM_IN(NUM_IN)) i_ctrl (
    .chanAvail (chanAvail),
    .strobe    (strobe)
  );

  lis_shell_dpath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .WIDTH(WIDTH), .QDEPTH(QDEPTH)
  ) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inData    (inData),
    .strobe    (strobe),
    .chanAvail (chanAvail),
    .chanFull  (chanFull),
    .coreValid (coreValid),
    .coreData  (coreData)
  );

  generate
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_outRelay
      lis_relay_chain #(.WIDTH(WIDTH), .DEPTH(OUT_DEPTH)) i_relay (
        .clk      (clk),
        .rst      (rst),
        .inValid  (coreValid[j]),
        .inData   (coreData[j*WIDTH +: WIDTH]),
        .outValid (outValid[j]),
        .outData  (outData[j*WIDTH +: WIDTH])
      );
    end
  endgenerate
endmodule

// File: rtl/lat_ins_shell_chk.sv
module lat_ins_shell_chk #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2,
  parameter int WIDTH   = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_IN-1:0]        inValid,
  input logic [NUM_IN-1:0]        chanAvail,
  input logic [NUM_IN-1:0]        chanFull,
  input logic                     fireNow,
  input logic [NUM_OUT-1:0]       coreValid,
  input logic [NUM_OUT*WIDTH-1:0] coreData,
  input logic [NUM_OUT-1:0]       outValid
);
  AST_FIRE_EMIT: assert property (@(posedge clk) disable iff (rst)
    (&chanAvail) |=> (&coreValid)); // R2

  AST_STALL_SPREAD: assert property (@(posedge clk) disable iff (rst)
    !(&chanAvail) |=> (coreValid == '0)); // R3

  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
    !(&chanAvail) |=> $stable(coreData)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ((inValid & chanFull & ~{NUM_IN{fireNow}}) == '0)); // R7

  AST_OUT_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (outValid == '0) || (outValid == '1)); // R8
endmodule

bind lat_ins_shell lat_ins_shell_chk #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .WIDTH(WIDTH)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .chanAvail (chanAvail),
  .chanFull  (chanFull),
  .fireNow   (fireNow),
  .coreValid (coreValid),
  .coreData  (coreData),
  .outValid  (outValid)
);

// File: tb/test_lat_ins_shell.sv
module test_lat_ins_shell;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IN  = 3;
  localparam int NUM_OUT = 2;
  localparam int W       = 16;
  localparam int LAT     = 5;     // deepest input chain 3 + shell 1 + output 1
  localparam int MAXEV   = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NUM_IN-1:0]     srcValid;
  logic [NUM_IN*W-1:0]   srcData;
  logic [NUM_IN-1:0]     dutInValid;
  logic [NUM_IN*W-1:0]   dutInData;
  logic [NUM_OUT-1:0]    outValid;
  logic [NUM_OUT*W-1:0]  outData;

  // input channels with differing relay depth: 0, 1, 3
  lis_relay_chain #(.WIDTH(W), .DEPTH(0)) i_rs0 (.clk(clk), .rst(rst),
    .inValid(srcValid[0]), .inData(srcData[0 +: W]),
    .outValid(dutInValid[0]), .outData(dutInData[0 +: W]));
  lis_relay_chain #(.WIDTH(W), .DEPTH(1)) i_rs1 (.clk(clk), .rst(rst),
    .inValid(srcValid[1]), .inData(srcData[W +: W]),
    .outValid(dutInValid[1]), .outData(dutInData[W +: W]));
  lis_relay_chain #(.WIDTH(W), .DEPTH(3)) i_rs2 (.clk(clk), .rst(rst),
    .inValid(srcValid[2]), .inData(srcData[2*W +: W]),
    .outValid(dutInValid[2]), .outData(dutInData[2*W +: W]));

  lat_ins_shell i_lat_ins_shell (
    .clk(clk), .rst(rst),
    .inValid(dutInValid), .inData(dutInData),
    .outValid(outValid), .outData(outData)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int nSent   = 0;
  int nextOut = 0;
  int          sendT  [MAXEV];
  logic [W-1:0] prefix [MAXEV];
  logic          histV [MAXEV];
  logic [W-1:0]  histD [MAXEV];
  logic [W-1:0]  lastData = '0;
  bit done = 0;

  function automatic logic [W-1:0] expectedOut(input int n);
    return prefix[n];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // outputs and relay chain checked at the falling edge, then source driven
  task automatic doCycle(input bit send);
    logic expValid;
    logic [W-1:0] sum;
    @(negedge clk);
    cyc++;
    if (nextOut == 0) expValid = (cyc == 1);
    else expValid = (nextOut - 1 < nSent) && (sendT[nextOut-1] + LAT == cyc);
    // R2 R3: exact cycle of every informative event; R8: all channels agree
    check(expValid ? "R2" : "R3", {30'd0, outValid}, expValid ? 32'h3 : 32'h0);
    for (int j = 0; j < NUM_OUT; j++) begin
      if (expValid)
        check(nextOut == 0 ? "R1" : "R5 R8", {16'd0, outData[j*W +: W]},
              {16'd0, expectedOut(nextOut)});
      else
        check("R4", {16'd0, outData[j*W +: W]}, {16'd0, lastData});
    end
    if (expValid) begin
      lastData = expectedOut(nextOut);
      nextOut++;
    end
    // R6: depth-3 chain replays the source three cycles later
    if (cyc >= 3) begin
      check("R6", {31'd0, dutInValid[2]}, {31'd0, histV[cyc-3]});
      if (histV[cyc-3]) check("R6", {16'd0, dutInData[2*W +: W]}, {16'd0, histD[cyc-3]});
    end else begin
      check("R6", {31'd0, dutInValid[2]}, 32'd0);
    end
    // drive source; void cycles carry junk data that must be ignored (R5)
    for (int c = 0; c < NUM_IN; c++) srcData[c*W +: W] = W'($urandom);
    if (send) begin
      srcValid = '1;
      sum = '0;
      for (int c = 0; c < NUM_IN; c++) sum = sum + srcData[c*W +: W];
      sendT[nSent] = cyc;
      prefix[nSent+1] = prefix[nSent] + sum;
      nSent++;
    end else begin
      srcValid = '0;
    end
    histV[cyc] = srcValid[2];
    histD[cyc] = srcData[2*W +: W];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7321));
    srcValid = '0;
    srcData  = '0;
    prefix[0] = '0;
    histV[0] = 1'b0;
    histD[0] = '0;
    // R1: outputs void during reset
    repeat (3) begin
      @(negedge clk);
      check("R1", {30'd0, outValid}, 32'd0);
      check("R6", {31'd0, dutInValid[2]}, 32'd0);
    end
    @(negedge clk);
    rst = 1'b0;   // cyc 0
    // directed: no input at all, only the initial event then stalls
    for (int i = 0; i < 8; i++) doCycle(1'b0);
    // directed: back-to-back burst
    for (int i = 0; i < 20; i++) doCycle(1'b1);
    // directed: isolated single events
    for (int i = 0; i < 30; i++) doCycle(i % 7 == 0);
    // constrained random: mixed densities
    for (int i = 0; i < 1200; i++) begin
      int pct;
      pct = (i < 600) ? 60 : 85;
      doCycle(($urandom % 100) < pct);
    end
    // drain
    for (int i = 0; i < 12; i++) doCycle(1'b0);
    // R5 R7: every event produced exactly once, none lost in the queues
    check("R5 R7", nextOut, nSent + 1);
    done = 1;
    summary();
  end
endmodule